// File: doc/BRIEF.md
# 10BASE-T Manchester Line Transmitter

This block turns a stream of 4-bit transmit nibbles into a single Manchester-coded line for a 10 Mb/s twisted-pair link. It runs on a 20 MHz clock, so each data bit takes two clock cycles, one per half-bit cell, and each nibble takes eight cycles. Between frames it keeps the link alive by sending a short positive link pulse at a fixed interval. A frame ends with a short high end-of-transmission level before the idle pulse schedule starts again.

In half-duplex operation the block returns every transmitted nibble on a receive-side nibble output with a valid flag, and it keeps the collision line low while it does so. After each half-duplex frame it produces a heartbeat pulse on the collision line after a set delay. In full-duplex operation both the loopback and the heartbeat are off. The encoded line and an "active" flag are the transmit outputs. Pulse shaping and the analog drivers follow this block and are not part of it.

Top module: `tbt_manchester_tx`

## Requirements
- R1: While reset is held and on the first cycle after it, `line_o`, `active_o`, `col_o`, `rx_dv_o` are 0 and `rx_nib_o` is 0.
- R2: When `tx_en_i` is sampled high at a clock edge while idle, a frame starts at that edge. The nibble on `tx_nib_i` is sent as four bits, least significant bit first, over the next eight cycles.
- R3: Each data bit takes two cycles. A 1 is sent as a low cycle then a high cycle, and a 0 as a high cycle then a low cycle. The line therefore changes at every mid-bit.
- R4: `tx_en_i` and `tx_nib_i` are sampled only at nibble boundaries, which fall every eight cycles from the frame start. When `tx_en_i` is low at a boundary, the line is held high for `ETI_CYC` cycles (default 5, or 250 ns) and the block then goes idle. Input values between boundaries, and any input during that high period, have no effect.
- R5: While idle, the line is low except for a two-cycle high link pulse. The pulse occupies idle cycles `NLP_PERIOD`-2 and `NLP_PERIOD`-1, counted from reset or from the end of the last frame, and then repeats every `NLP_PERIOD` cycles. A frame start restarts this count.
- R6: If `half_duplex_i` is high when a nibble is loaded, `rx_dv_o` is 1 and `rx_nib_o` equals that nibble for the eight cycles it is on the line. Otherwise `rx_dv_o` and `rx_nib_o` are 0.
- R7: If `half_duplex_i` is high at the boundary where a frame ends, `col_o` goes high `SQE_DLY` cycles after the line enters its end-of-frame high level and stays high for `SQE_LEN` cycles. A new frame start cancels it. `col_o` is never high while `rx_dv_o` is high, and it never rises after a full-duplex frame end.
- R8: `active_o` is high from the frame start edge through the last end-of-frame high cycle, and low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz bit-cell clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Frame enable, sampled at nibble boundaries |
| tx_nib_i | input | 4 | Transmit nibble, sent LSB first |
| half_duplex_i | input | 1 | 1 selects half-duplex loopback and heartbeat |
| line_o | output | 1 | Manchester-coded line, link pulses while idle |
| active_o | output | 1 | High while a frame or its end level is on the line |
| rx_nib_o | output | 4 | Looped-back nibble in half duplex |
| rx_dv_o | output | 1 | Loopback nibble valid |
| col_o | output | 1 | Collision line, carries only the heartbeat pulse |

## Verification
The bench builds the block with `NLP_PERIOD` = 40, `SQE_DLY` = 3, `SQE_LEN` = 4 and the default `ETI_CYC` = 5. With these values many link pulses fall inside a few thousand cycles. Heartbeat windows can also overlap the idle gap and a following frame, so the cancel case and the pulse-restart case both occur. The 16 ms default interval would leave these cases out of reach.

// File: rtl/tbt_mtx_pkg.sv
package tbt_mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_ETI  = 2'd2
    } mtx_state_e;

    localparam int unsigned CELLS_PER_NIB = 8;
    localparam int unsigned PH_W = $clog2(CELLS_PER_NIB);
endpackage

// File: rtl/tbt_nlp_sched.sv
module tbt_nlp_sched #(
    parameter int unsigned NLP_PERIOD = 320000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic pulse_next_o
);
    localparam int unsigned CW = $clog2(NLP_PERIOD);
    localparam logic [CW-1:0] LAST   = CW'(NLP_PERIOD - 1);
    localparam logic [CW-1:0] P_FROM = CW'(NLP_PERIOD - 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } nlp_s;

    nlp_s d, q;

    always_comb begin
        d = q;
        if (hold_i) begin
            d.cnt = '0;
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        pulse_next_o = !hold_i && (d.cnt >= P_FROM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tbt_sqe_timer.sv
module tbt_sqe_timer #(
    parameter int unsigned SQE_DLY = 16,
    parameter int unsigned SQE_LEN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic col_next_o
);
    localparam int unsigned TOT = SQE_DLY + SQE_LEN;
    localparam int unsigned CW  = $clog2(TOT + 1);
    localparam logic [CW-1:0] TOT_V = CW'(TOT);
    localparam logic [CW-1:0] DLY_V = CW'(SQE_DLY);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } sqe_s;

    sqe_s d, q;

    always_comb begin
        d = q;
        if (cancel_i) begin
            d.cnt = '0;
        end else if (start_i) begin
            d.cnt = CW'(1);
        end else if (q.cnt == '0 || q.cnt == TOT_V) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        col_next_o = (d.cnt > DLY_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tbt_manchester_tx.sv
module tbt_manchester_tx
    import tbt_mtx_pkg::*;
#(
    parameter int unsigned NLP_PERIOD = 320000,
    parameter int unsigned ETI_CYC    = 5,
    parameter int unsigned SQE_DLY    = 16,
    parameter int unsigned SQE_LEN    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en_i,
    input  logic [3:0] tx_nib_i,
    input  logic       half_duplex_i,
    output logic       line_o,
    output logic       active_o,
    output logic [3:0] rx_nib_o,
    output logic       rx_dv_o,
    output logic       col_o
);
    localparam int unsigned EW = $clog2(ETI_CYC + 1);
    localparam logic [EW-1:0] ETI_LAST = EW'(ETI_CYC - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELLS_PER_NIB - 1);

    typedef struct packed {
        mtx_state_e      st;
        logic [PH_W-1:0] ph;
        logic [3:0]      sh;
        logic [EW-1:0]   eti;
        logic            line;
        logic            act;
        logic [3:0]      rxnib;
        logic            rxdv;
        logic            col;
    } tx_s;

    tx_s d, q;

    logic load_w;
    logic end_w;
    logic nlp_next_w;
    logic col_next_w;
    logic hold_w;

    mtx_state_e      st_q_w;
    logic [PH_W-1:0] ph_q_w;
    assign st_q_w = q.st;
    assign ph_q_w = q.ph;

    tbt_nlp_sched #(.NLP_PERIOD(NLP_PERIOD)) u_nlp (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold_w),
        .pulse_next_o(nlp_next_w)
    );

    tbt_sqe_timer #(.SQE_DLY(SQE_DLY), .SQE_LEN(SQE_LEN)) u_sqe (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (end_w),
        .cancel_i  (load_w),
        .col_next_o(col_next_w)
    );

    // Frame control: load at idle or at a boundary, end at a boundary.
    always_comb begin
        load_w = 1'b0;
        end_w  = 1'b0;
        unique case (q.st)
            ST_IDLE: load_w = tx_en_i;
            ST_DATA: begin
                if (q.ph == PH_LAST) begin
                    load_w = tx_en_i;
                    end_w  = !tx_en_i && half_duplex_i;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: ;
            ST_DATA: begin
                if (q.ph == PH_LAST) begin
                    if (!tx_en_i) begin
                        d.st    = ST_ETI;
                        d.eti   = '0;
                        d.rxdv  = 1'b0;
                        d.rxnib = '0;
                    end
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            ST_ETI: begin
                if (q.eti == ETI_LAST) d.st = ST_IDLE;
                else                   d.eti = q.eti + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        if (load_w) begin
            d.st    = ST_DATA;
            d.ph    = '0;
            d.sh    = tx_nib_i;
            d.rxdv  = half_duplex_i;
            d.rxnib = half_duplex_i ? tx_nib_i : 4'h0;
        end

        hold_w = (d.st != ST_IDLE);
        d.act  = hold_w;

        unique case (d.st)
            ST_DATA: d.line = d.ph[0] ? d.sh[d.ph[2:1]] : ~d.sh[d.ph[2:1]];
            ST_ETI:  d.line = 1'b1;
            default: d.line = nlp_next_w;
        endcase

        d.col = col_next_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign line_o   = q.line;
    assign active_o = q.act;
    assign rx_nib_o = q.rxnib;
    assign rx_dv_o  = q.rxdv;
    assign col_o    = q.col;
endmodule

// File: rtl/tbt_manchester_tx_chk.sv
module tbt_manchester_tx_chk
    import tbt_mtx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       line_o,
    input logic       active_o,
    input logic       rx_dv_o,
    input logic       col_o,
    input mtx_state_e st,
    input logic [2:0] ph
);
    // Second half cell always inverts the first one.
    p_mid_bit_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && ph[0]) |-> (line_o != $past(line_o)));

    // End-of-frame level is high.
    p_eti_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ETI) |-> line_o);

    // Link pulse lasts exactly two cycles.
    p_nlp_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && line_o && $past(line_o) && $past(st) == ST_IDLE)
        |=> (!line_o || active_o));

    // Loopback never raises collision.
    p_loop_no_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv_o |-> !col_o);

    // Loopback valid only inside an active frame.
    p_dv_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv_o |-> active_o);

    // Active tracks non-idle state.
    p_active_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active_o == (st != ST_IDLE));
endmodule

bind tbt_manchester_tx tbt_manchester_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_o  (line_o),
    .active_o(active_o),
    .rx_dv_o (rx_dv_o),
    .col_o   (col_o),
    .st      (st_q_w),
    .ph      (ph_q_w)
);

// File: tb/tbt_manchester_tx_tb_top.sv
`timescale 1ns/1ps
module tbt_manchester_tx_tb_top;
    localparam int P   = 40;
    localparam int ETI = 5;
    localparam int SD  = 3;
    localparam int SL  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] tx_nib = 4'h0;
    logic       hd = 1'b0;
    logic       line, active, rx_dv, col;
    logic [3:0] rx_nib;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tbt_manchester_tx #(.NLP_PERIOD(P), .ETI_CYC(ETI), .SQE_DLY(SD), .SQE_LEN(SL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .tx_nib_i(tx_nib),
        .half_duplex_i(hd), .line_o(line), .active_o(active),
        .rx_nib_o(rx_nib), .rx_dv_o(rx_dv), .col_o(col)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Expected line value from a bit and its half cell (R3).
    function automatic bit cell_val(input bit b, input bit second);
        return second ? b : ~b;
    endfunction

    // Reference model, advanced at every rising edge.
    int m_st = 0;          // 0 idle, 1 data, 2 end level
    int m_ph = 0, m_eti = 0, m_idle = 0, m_sq = 0;
    bit [3:0] m_nib = 0, m_rxn = 0;
    bit m_dv = 0;
    bit compare_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_eti = 0; m_idle = 0; m_sq = 0;
            m_nib = 0; m_rxn = 0; m_dv = 0;
        end else begin
            bit ld, fin;
            ld = 0; fin = 0;
            case (m_st)
                0: if (tx_en) ld = 1; else m_idle = (m_idle + 1) % P;
                1: if (m_ph == 7) begin
                       if (tx_en) ld = 1;
                       else begin m_st = 2; m_eti = 0; fin = 1; m_dv = 0; m_rxn = 0; end
                   end else m_ph++;
                default: if (m_eti == ETI - 1) begin m_st = 0; m_idle = 1; end
                         else m_eti++;
            endcase
            if (ld) begin
                m_st = 1; m_ph = 0; m_nib = tx_nib; m_idle = 0;
                m_dv = hd; m_rxn = hd ? tx_nib : 4'h0;
                m_sq = 0;
            end else if (fin && hd) m_sq = 1;
            else if (m_sq != 0) m_sq = (m_sq == SD + SL) ? 0 : m_sq + 1;
        end
    end

    function automatic bit exp_line();
        if (m_st == 1) return cell_val(m_nib[m_ph/2], m_ph[0]);
        if (m_st == 2) return 1'b1;
        return (m_idle >= P - 2);
    endfunction

    always @(negedge clk) begin
        if (compare_on) begin
            bit el;
            el = exp_line();
            if (m_st == 1)      chk(line == el, "R2 R3 data cell", line, el);
            else if (m_st == 2) chk(line == el, "R4 end level", line, el);
            else                chk(line == el, "R5 idle pulse", line, el);
            chk(active == (m_st != 0), "R8 active", active, m_st != 0);
            chk(rx_dv == m_dv, "R6 rx_dv", rx_dv, m_dv);
            chk(rx_nib == m_rxn, "R6 rx_nib", rx_nib, m_rxn);
            chk(col == (m_sq > SD), "R7 col", col, m_sq > SD);
        end
    end

    task automatic step(input bit en, input bit [3:0] nib);
        tx_en = en; tx_nib = nib;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(line == 0 && active == 0 && col == 0 && rx_dv == 0 && rx_nib == 0,
            "R1 reset outputs", {line, active, col, rx_dv}, 0);
        rst_n = 1'b1;
        compare_on = 1'b1;

        // Idle link pulses: first pulse after idle edges P-2, P-1 (R5).
        for (int i = 1; i <= P + 2; i++) begin
            step(0, 4'($urandom));
            if (i == P - 3) chk(line == 0, "R5 pre-pulse low", line, 0);
            if (i == P - 2) chk(line == 1, "R5 pulse first", line, 1);
            if (i == P - 1) chk(line == 1, "R5 pulse second", line, 1);
            if (i == P)     chk(line == 0, "R5 pulse end", line, 0);
        end

        // Directed nibble 0x6 full duplex: cells 1,0 0,1 0,1 1,0 (R2, R3).
        hd = 1'b0;
        step(1, 4'h6);
        begin
            bit [7:0] pat;
            pat = 8'b1001_0110; // cell order 0..7 as bit 7..0: 1,0,0,1,0,1,1,0
            for (int c = 0; c < 8; c++) begin
                chk(line == pat[7-c], "R2 R3 nibble 6 LSB first", line, pat[7-c]);
                chk(rx_dv == 0, "R6 full duplex no loopback", rx_dv, 0);
                step(c == 7 ? 1'b0 : 1'b1, 4'hF); // mid-nibble values ignored (R4)
            end
        end
        // Now in end level; tx_en pulses here are ignored (R4).
        for (int c = 0; c < ETI + SD + SL; c++) begin
            chk(col == 0, "R7 no heartbeat in full duplex", col, 0);
            step(1'($urandom), 4'($urandom));
        end
        step(0, 0);
        while (active) step(0, 0);

        // Half duplex frame with heartbeat (R6, R7).
        hd = 1'b1;
        step(1, 4'hA);
        chk(rx_dv == 1 && rx_nib == 4'hA, "R6 loopback nibble", rx_nib, 4'hA);
        repeat (7) step(1'($urandom), 4'($urandom));
        step(0, 0); // boundary sampled low: end level starts
        for (int c = 1; c <= SD + SL + 2; c++) begin
            chk(col == (c > SD && c <= SD + SL), "R7 heartbeat window", col,
                (c > SD && c <= SD + SL));
            step(0, 0);
        end

        // Constrained random traffic.
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 49) == 0) hd = ~hd;
            step($urandom_range(0, 9) < 7, 4'($urandom));
        end
        for (int n = 0; n < 2 * P; n++) step(0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule